// File: doc/BRIEF.md
# Reloadable Up/Down Core Timer

This block is a free-standing 16-bit timer core for a peripheral subsystem. Software drives it through a small register bus that has a write strobe, a two-bit address, write data and combinational read data. Through that bus it reaches four locations: a control word, the live count, a reload value and an interrupt status flag. Counting is paced by a single-cycle tick input, which carries the already-prescaled timer clock.

While the run bit is set, every tick moves the count one step up or down, as the direction bit selects. Software may change the direction in mid-run. The count wraps at the top of its range when counting up and at zero when counting down. On each wrap the block inverts an output toggle latch, emits a one-cycle wrap pulse and sets a sticky interrupt flag. If the reload bit is set, the count takes the reload register's value at the wrap instead of rolling over.

Software can also force the toggle latch through the control word, and that write is honoured whether or not the timer is running. When a software write and a tick (or a wrap) hit in the same cycle, the software write wins.

Top module: `updown_core_timer`

## Requirements
- R1: After reset the control word, count, reload value, toggle output, wrap pulse and interrupt flag are all zero.
- R2: The mode field (control bits [5:3]) is stored and read back. Every mode code, including the reserved non-zero codes, counts exactly as timer mode does.
- R3: With the run bit (control bit 6) at 0 the count holds through ticks. With it at 1 the count moves one step per cycle in which tick_i is high, and holds in cycles where tick_i is low.
- R4: The direction bit (control bit 7) selects counting up when 0 and down when 1. A change written while running applies from the next tick.
- R5: The toggle output inverts when a tick arrives at 0xFFFF while counting up, and when a tick arrives at 0x0000 while counting down.
- R6: A write to the control word loads control bit 10 into the toggle output, whether the timer is running or stopped.
- R7: With the reload bit (control bit 15) at 1, a wrapping tick loads the count from the reload register. With it at 0, the count rolls over to 0x0000 (up) or 0xFFFF (down).
- R8: Each wrap drives wrap_pulse_o high for the cycle after the wrapping edge and sets irq_o. irq_o stays set until software writes data bit 0 = 1 to address 3. Writing 0 there leaves it set.
- R9: The input-select field (bits [2:0]), the mode field, run, direction, toggle and reload bits read back at their positions. Every other control bit reads 0, so a write of 0xFFFF reads back as 0x84FF. The input-select value has no effect on counting.
- R10: A count write in the same cycle as a tick stores the written value and causes no wrap. A control write in the same cycle as a wrap leaves the toggle at the written bit 10, while the count still wraps.
- R11: The address map is 0 = control, 1 = count, 2 = reload, 3 = interrupt status (bit 0). Count and reload read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| tick_i | input | 1 | Prescaled count enable, one step per high cycle |
| toggle_o | output | 1 | Output toggle latch |
| wrap_pulse_o | output | 1 | One-cycle pulse after each overflow or underflow |
| irq_o | output | 1 | Sticky interrupt request |

## Verification
The bench sweeps every start value within sixteen steps of each wrap point against tick bursts of zero to twenty. It does this in both directions, with reload on and off, and uses reload values that force repeated wraps inside one burst. A design that detected the limit one step late, or that reloaded without toggling, would show a wrong final count or toggle parity. The bench also forces a count write and a control write to land on a tick edge. A design that let the tick win there would either corrupt the written count or flip the toggle latch away from the written value. Further checks confirm that a direction change in mid-run takes effect at once, and that the pulse lasts exactly one cycle while the interrupt flag stays sticky. A design with a combinational pulse or a self-clearing flag fails those checks.

// File: rtl/uct_pkg.sv
package uct_pkg;

  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned CTRL_W  = 16;
  localparam int unsigned INSEL_W = 3;
  localparam int unsigned MODE_W  = 3;

  // control word bit positions (software-visible layout)
  localparam int unsigned B_INSEL = 0;
  localparam int unsigned B_MODE  = 3;
  localparam int unsigned B_RUN   = 6;
  localparam int unsigned B_DOWN  = 7;
  localparam int unsigned B_TOG   = 10;
  localparam int unsigned B_RLD   = 15;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 2'd0,
    A_COUNT  = 2'd1,
    A_RELOAD = 2'd2,
    A_IRQ    = 2'd3
  } uct_addr_e;

  typedef struct packed {
    logic               reload_en;
    logic               toggle;
    logic               down;
    logic               run;
    logic [MODE_W-1:0]  mode;
    logic [INSEL_W-1:0] insel;
  } uct_ctrl_t;

endpackage

// File: rtl/uct_ctrl_reg.sv
module uct_ctrl_reg
  import uct_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_i,
  input  uct_ctrl_t wval_i,
  input  logic      wrap_i,
  output uct_ctrl_t ctrl_o
);

  uct_ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_i) begin
      ctrl_d = wval_i;              // software value wins over a wrap
    end else if (wrap_i) begin
      ctrl_d.toggle = ~ctrl_q.toggle;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl_o = ctrl_q;

endmodule

// File: rtl/uct_counter.sv
module uct_counter #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             down_i,
  input  logic             reload_en_i,
  input  logic             cnt_wr_i,
  input  logic             rld_wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic [WIDTH-1:0] reload_o,
  output logic             wrap_o
);

  localparam logic [WIDTH-1:0] CNT_MAX = '1;
  localparam logic [WIDTH-1:0] CNT_MIN = '0;
  localparam logic [WIDTH-1:0] ONE     = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic [WIDTH-1:0] rld_q, rld_d;
  logic [WIDTH-1:0] stepped;
  logic             advance;
  logic             at_limit;

  assign advance  = run_i & tick_i & ~cnt_wr_i;
  assign at_limit = down_i ? (cnt_q == CNT_MIN) : (cnt_q == CNT_MAX);
  assign wrap_o   = advance & at_limit;
  assign stepped  = down_i ? (cnt_q - ONE) : (cnt_q + ONE);

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_wr_i) begin
      cnt_d = wdata_i;
    end else if (advance) begin
      cnt_d = (at_limit && reload_en_i) ? rld_q : stepped;
    end
  end

  always_comb begin
    rld_d = rld_q;
    if (rld_wr_i) begin
      rld_d = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      rld_q <= rld_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign reload_o = rld_q;

endmodule

// File: rtl/uct_irq.sv
module uct_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wrap_i,
  input  logic clr_i,
  output logic pulse_o,
  output logic flag_o
);

  logic pulse_q, pulse_d;
  logic flag_q, flag_d;

  always_comb begin
    pulse_d = wrap_i;
    flag_d  = wrap_i | (flag_q & ~clr_i);   // a new event beats the clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
      flag_q  <= flag_d;
    end
  end

  assign pulse_o = pulse_q;
  assign flag_o  = flag_q;

endmodule

// File: rtl/updown_core_timer.sv
module updown_core_timer
  import uct_pkg::*;
#(
  parameter int unsigned WIDTH = 16   // must be at least CTRL_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [WIDTH-1:0]    wdata_i,
  output logic [WIDTH-1:0]    rdata_o,
  input  logic                tick_i,
  output logic                toggle_o,
  output logic                wrap_pulse_o,
  output logic                irq_o
);

  localparam int unsigned PAD_W = WIDTH - CTRL_W;

  uct_ctrl_t        ctrl_q;
  uct_ctrl_t        ctrl_wval;
  logic             ctrl_wr, cnt_wr, rld_wr, irq_clr;
  logic             wrap;
  logic [WIDTH-1:0] cnt_q, reload_q;
  logic             run_s, down_s, rld_en_s;
  logic [CTRL_W-1:0] ctrl_rd;

  // bus decode
  assign ctrl_wr = wr_en_i && (addr_i == A_CTRL);
  assign cnt_wr  = wr_en_i && (addr_i == A_COUNT);
  assign rld_wr  = wr_en_i && (addr_i == A_RELOAD);
  assign irq_clr = wr_en_i && (addr_i == A_IRQ) && wdata_i[0];

  always_comb begin
    ctrl_wval.insel     = wdata_i[B_INSEL +: INSEL_W];
    ctrl_wval.mode      = wdata_i[B_MODE +: MODE_W];
    ctrl_wval.run       = wdata_i[B_RUN];
    ctrl_wval.down      = wdata_i[B_DOWN];
    ctrl_wval.toggle    = wdata_i[B_TOG];
    ctrl_wval.reload_en = wdata_i[B_RLD];
  end

  uct_ctrl_reg u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (ctrl_wr),
    .wval_i (ctrl_wval),
    .wrap_i (wrap),
    .ctrl_o (ctrl_q)
  );

  assign run_s    = ctrl_q.run;
  assign down_s   = ctrl_q.down;
  assign rld_en_s = ctrl_q.reload_en;

  // every mode code counts as plain timer mode
  uct_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .run_i       (run_s),
    .down_i      (down_s),
    .reload_en_i (rld_en_s),
    .cnt_wr_i    (cnt_wr),
    .rld_wr_i    (rld_wr),
    .wdata_i     (wdata_i),
    .cnt_o       (cnt_q),
    .reload_o    (reload_q),
    .wrap_o      (wrap)
  );

  uct_irq u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wrap_i  (wrap),
    .clr_i   (irq_clr),
    .pulse_o (wrap_pulse_o),
    .flag_o  (irq_o)
  );

  always_comb begin
    ctrl_rd                      = '0;
    ctrl_rd[B_INSEL +: INSEL_W]  = ctrl_q.insel;
    ctrl_rd[B_MODE +: MODE_W]    = ctrl_q.mode;
    ctrl_rd[B_RUN]               = ctrl_q.run;
    ctrl_rd[B_DOWN]              = ctrl_q.down;
    ctrl_rd[B_TOG]               = ctrl_q.toggle;
    ctrl_rd[B_RLD]               = ctrl_q.reload_en;
  end

  generate
    if (PAD_W > 0) begin : g_wide
      always_comb begin
        unique case (addr_i)
          A_CTRL:   rdata_o = {{PAD_W{1'b0}}, ctrl_rd};
          A_COUNT:  rdata_o = cnt_q;
          A_RELOAD: rdata_o = reload_q;
          default:  rdata_o = {{(WIDTH-1){1'b0}}, irq_o};
        endcase
      end
    end else begin : g_exact
      always_comb begin
        unique case (addr_i)
          A_CTRL:   rdata_o = ctrl_rd;
          A_COUNT:  rdata_o = cnt_q;
          A_RELOAD: rdata_o = reload_q;
          default:  rdata_o = {{(WIDTH-1){1'b0}}, irq_o};
        endcase
      end
    end
  endgenerate

  assign toggle_o = ctrl_q.toggle;

endmodule

// File: rtl/uct_checker.sv
module uct_checker
  import uct_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              tick_i,
  input logic              run_i,
  input logic              down_i,
  input logic              rld_en_i,
  input logic [WIDTH-1:0]  cnt_i,
  input logic [WIDTH-1:0]  reload_i,
  input logic              toggle_o,
  input logic              wrap_pulse_o,
  input logic              irq_o
);

  localparam logic [WIDTH-1:0] CMAX = '1;
  localparam logic [WIDTH-1:0] CMIN = '0;

  logic cw, kw;
  assign cw = wr_en_i && (addr_i == A_COUNT);
  assign kw = wr_en_i && (addr_i == A_CTRL);

  // R3: stopped timer holds its count
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cw) |=> $stable(cnt_i));

  // R4: up step
  a_r4_up_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && !down_i && !cw && cnt_i != CMAX)
      |=> cnt_i == WIDTH'($past(cnt_i) + 1'b1));

  // R4: down step
  a_r4_down_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && down_i && !cw && cnt_i != CMIN)
      |=> cnt_i == WIDTH'($past(cnt_i) - 1'b1));

  // R7: reload at wrap
  a_r7_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && rld_en_i && !cw &&
     ((down_i && cnt_i == CMIN) || (!down_i && cnt_i == CMAX)))
      |=> cnt_i == $past(reload_i));

  // R5: toggle flips with each pulse unless software wrote the control word
  a_r5_toggle_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_pulse_o && !$past(kw)) |-> toggle_o != $past(toggle_o));

  // R8: pulse always comes with a raised interrupt flag
  a_r8_irq_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_pulse_o |-> irq_o);

endmodule

bind updown_core_timer uct_checker #(.WIDTH(WIDTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .addr_i       (addr_i),
  .tick_i       (tick_i),
  .run_i        (run_s),
  .down_i       (down_s),
  .rld_en_i     (rld_en_s),
  .cnt_i        (cnt_q),
  .reload_i     (reload_q),
  .toggle_o     (toggle_o),
  .wrap_pulse_o (wrap_pulse_o),
  .irq_o        (irq_o)
);

// File: tb/tb_updown_core_timer.sv
`timescale 1ns/1ps
module tb_updown_core_timer;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        wr_en_i;
  logic [1:0]  addr_i;
  logic [15:0] wdata_i;
  logic [15:0] rdata_o;
  logic        tick_i;
  logic        toggle_o;
  logic        wrap_pulse_o;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk_i = ~clk_i;

  updown_core_timer dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .rdata_o      (rdata_o),
    .tick_i       (tick_i),
    .toggle_o     (toggle_o),
    .wrap_pulse_o (wrap_pulse_o),
    .irq_o        (irq_o)
  );

  localparam logic [1:0] AC = 2'd0, AN = 2'd1, AR = 2'd2, AI = 2'd3;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [15:0] exp);
    addr_i = a;
    #1;
    check(req, rdata_o, exp);
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk_i);
      tick_i = 1'b1;
      repeat (n) @(negedge clk_i);
      tick_i = 1'b0;
    end
  endtask

  // sweep one case against an arithmetic model
  task automatic sweep_case(input logic [15:0] start, input int n, input bit down,
                            input bit rel_en, input logic [15:0] rel);
    logic [15:0] c;
    int wraps;
    c = start; wraps = 0;
    for (int i = 0; i < n; i++) begin
      if ((down && c == 16'h0000) || (!down && c == 16'hFFFF)) begin
        wraps++;
        c = rel_en ? rel : (down ? 16'hFFFF : 16'h0000);
      end else begin
        c = down ? c - 16'd1 : c + 16'd1;
      end
    end
    wr(AR, rel);
    wr(AN, start);
    wr(AI, 16'h0001);
    wr(AC, 16'h0040 | (16'(down) << 7) | (16'(rel_en) << 15));
    ticks(n);
    rd_chk(rel_en ? "R7 count" : "R4 count", AN, c);
    check("R5 toggle parity", {15'd0, toggle_o}, {15'd0, wraps[0]});
    check("R8 irq after sweep", {15'd0, irq_o}, {15'd0, wraps > 0});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; wr_en_i = 1'b0; addr_i = '0; wdata_i = '0; tick_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd_chk("R1 ctrl", AC, 16'h0000);
    rd_chk("R1 count", AN, 16'h0000);
    rd_chk("R1 reload", AR, 16'h0000);
    rd_chk("R1 irq", AI, 16'h0000);
    check("R1 toggle", {15'd0, toggle_o}, 16'd0);
    check("R1 pulse", {15'd0, wrap_pulse_o}, 16'd0);

    // R11 register map readback
    wr(AR, 16'hBEEF);
    wr(AN, 16'h1357);
    rd_chk("R11 reload rb", AR, 16'hBEEF);
    rd_chk("R11 count rb", AN, 16'h1357);

    // R3 stopped holds, running without tick holds
    wr(AN, 16'h0055);
    ticks(7);
    rd_chk("R3 hold stopped", AN, 16'h0055);
    wr(AC, 16'h0040);
    repeat (5) @(negedge clk_i);
    rd_chk("R3 no tick no step", AN, 16'h0055);
    ticks(4);
    rd_chk("R3 steps per tick", AN, 16'h0059);

    // R9 layout and unused bits
    wr(AC, 16'hFFFF);
    rd_chk("R9 ctrl mask", AC, 16'h84FF);
    check("R9 toggle via full write", {15'd0, toggle_o}, 16'd1);
    wr(AN, 16'h0000);
    wr(AC, 16'h0047);
    ticks(6);
    rd_chk("R9 insel no effect", AN, 16'h0006);

    // R2 reserved mode counts as timer
    wr(AC, 16'h0068);
    rd_chk("R2 mode readback", AC, 16'h0068);
    wr(AN, 16'd10);
    ticks(4);
    rd_chk("R2 reserved mode counts", AN, 16'd14);

    // R4 direction change while running
    wr(AN, 16'd100);
    wr(AC, 16'h0040);
    ticks(3);
    wr(AC, 16'h00C0);
    ticks(5);
    rd_chk("R4 dir change", AN, 16'd98);

    // R6 toggle written stopped and running
    wr(AC, 16'h0400);
    check("R6 set stopped", {15'd0, toggle_o}, 16'd1);
    wr(AC, 16'h0440);
    check("R6 set running", {15'd0, toggle_o}, 16'd1);
    wr(AC, 16'h0040);
    check("R6 clear running", {15'd0, toggle_o}, 16'd0);

    // R8 pulse width and sticky flag
    wr(AI, 16'h0001);
    wr(AN, 16'hFFFF);
    @(negedge clk_i); tick_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0;
    check("R8 pulse high", {15'd0, wrap_pulse_o}, 16'd1);
    rd_chk("R5 wrap to zero", AN, 16'h0000);
    check("R5 toggle flipped", {15'd0, toggle_o}, 16'd1);
    @(negedge clk_i);
    check("R8 pulse one cycle", {15'd0, wrap_pulse_o}, 16'd0);
    check("R8 irq sticky", {15'd0, irq_o}, 16'd1);
    wr(AI, 16'h0000);
    check("R8 write 0 keeps irq", {15'd0, irq_o}, 16'd1);
    wr(AI, 16'h0001);
    check("R8 write 1 clears irq", {15'd0, irq_o}, 16'd0);

    // R10 count write beats tick
    wr(AC, 16'h0040);
    wr(AN, 16'hFFFF);
    @(negedge clk_i);
    tick_i = 1'b1; wr_en_i = 1'b1; addr_i = AN; wdata_i = 16'h1234;
    @(negedge clk_i);
    tick_i = 1'b0; wr_en_i = 1'b0;
    rd_chk("R10 count write wins", AN, 16'h1234);
    check("R10 no wrap on count write", {15'd0, irq_o}, 16'd0);

    // R10 control write beats toggle flip at wrap
    wr(AN, 16'hFFFF);
    @(negedge clk_i);
    tick_i = 1'b1; wr_en_i = 1'b1; addr_i = AC; wdata_i = 16'h0040;
    @(negedge clk_i);
    tick_i = 1'b0; wr_en_i = 1'b0;
    check("R10 toggle write wins", {15'd0, toggle_o}, 16'd0);
    rd_chk("R10 count still wraps", AN, 16'h0000);
    check("R10 irq on wrap", {15'd0, irq_o}, 16'd1);

    // R4 R5 R7 sweeps near both wrap points
    for (int d = 0; d < 2; d++) begin
      for (int r = 0; r < 2; r++) begin
        for (int s = 0; s < 16; s++) begin
          for (int n = 0; n <= 20; n++) begin
            sweep_case(d[0] ? 16'(s) : 16'(16'hFFF0 + s), n, d[0], r[0],
                       d[0] ? 16'h0005 : 16'hFFF8);
          end
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule